// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period

This block is a 16-bit up-counter that produces two edge-aligned pulse-width waveforms, channel A and channel B. The counter advances once for every clock on which the prescaler tick input is high. It climbs from zero to a period limit (TOP) and falls back to zero on the following tick. A mode field picks the period limit. There are three fixed limits (8, 9 and 10 bits). There are also two programmable sources: a period register, or the active compare value of channel A.

Software writes compare values into holding buffers. The buffers are copied to the active compare values only on the tick that ends a period, so a duty-cycle change never produces a partial pulse. Each channel drives either a non-inverted waveform or an inverted waveform, or it stays low. Four sticky flags report events: period end, compare A, compare B and capture-limit. Software clears a flag by writing a 1 to its bit.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 0, all flags are 0, both outputs are low, the buffers, active compares and period register are 0, and the mode is 0.
- R2: While running, the count rises by one on each clock with `tick` high. It does not change on clocks with `tick` low. On a tick where the count equals TOP it returns to 0.
- R3: Control register (address 0) holds the mode in bits [3:0], channel A control in [5:4] and channel B control in [7:6]. Mode 5 sets TOP to 0x00FF, mode 6 to 0x01FF, mode 7 to 0x03FF, mode 14 to the period register (address 3), and mode 15 to the active compare A value. In every other mode the counter holds and no flag sets.
- R4: A programmable TOP below 3 is treated as 3.
- R5: Flag bit 0 (period end) sets on each running tick where the count equals TOP. On that same tick, bit 3 (capture-limit) also sets in mode 14, and bit 1 also sets in mode 15.
- R6: Flag bit 1 sets on a running tick where the count equals the active compare A value. Flag bit 2 does the same for the active compare B value.
- R7: Flags stay set until a write to address 4 with a 1 in their bit position. A flag that sets on the same clock as its clear remains set.
- R8: Writes to addresses 1 (A) and 2 (B) land in holding buffers. The active compare values take the buffer contents on the tick where the count equals TOP, and at no other time.
- R9: With control value 2 an output is high while the count is below its active compare value and low otherwise. The effect is that it falls at the compare match and rises at zero.
- R10: With control value 3 an output is the complement of the R9 waveform.
- R11: With control value 0 or 1 the output is low.
- R12: If TOP is lowered below the current count, the counter runs on to 0xFFFF and wraps to 0 without setting the period-end flag. It then counts to the new TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 buffer A, 2 buffer B, 3 period, 4 flag clear) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| flags | output | 4 | Sticky flags: 0 period end, 1 compare A, 2 compare B, 3 capture-limit |
| out_a | output | 1 | Channel A waveform |
| out_b | output | 1 | Channel B waveform |

## Verification
Every result of a tick or a write is registered. This covers the count, the flags, the active compare values and the waveform levels, and each appears exactly one clock edge after the clock that carried the stimulus. The control bits take effect on the output through the same single edge. The bench changes inputs on the falling edge and lets one rising edge pass. It then compares every output on the next falling edge against a reference model advanced once per stimulus. Directed sequences pin the clamped period, simultaneous set and clear, the buffered load and the run past a lowered TOP to concrete values.

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int W       = 16,
  parameter int MIN_TOP = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [3:0]   flags,
  output logic         out_a,
  output logic         out_b
);
  localparam logic [3:0]   M_FIX8 = 4'd5, M_FIX9 = 4'd6, M_FIX10 = 4'd7;
  localparam logic [3:0]   M_PER = 4'd14, M_CMPA = 4'd15;
  localparam logic [W-1:0] FLOOR = W'(MIN_TOP);

  logic [3:0]   mode_q, flg_q, set_f, clr_f;
  logic [1:0]   ctl_a_q, ctl_b_q;
  logic [W-1:0] cnt_q, buf_a_q, buf_b_q, act_a_q, act_b_q, per_q;
  logic [W-1:0] top, nxt_cnt, nxt_a, nxt_b;
  logic         lvl_a_q, lvl_b_q, run, adv, at_top, wrap;

  always_comb begin
    run = 1'b1;
    case (mode_q)
      M_FIX8:  top = W'(16'h00FF);
      M_FIX9:  top = W'(16'h01FF);
      M_FIX10: top = W'(16'h03FF);
      M_PER:   top = (per_q < FLOOR) ? FLOOR : per_q;
      M_CMPA:  top = (act_a_q < FLOOR) ? FLOOR : act_a_q;
      default: begin run = 1'b0; top = '0; end
    endcase
  end

  assign at_top  = (cnt_q == top);
  assign adv     = tick & run;
  assign wrap    = adv & at_top;
  assign nxt_cnt = wrap ? '0 : cnt_q + W'(1);
  assign nxt_a   = wrap ? buf_a_q : act_a_q;
  assign nxt_b   = wrap ? buf_b_q : act_b_q;

  assign set_f[0] = wrap;
  assign set_f[1] = adv & ((cnt_q == act_a_q) | (at_top & (mode_q == M_CMPA)));
  assign set_f[2] = adv & (cnt_q == act_b_q);
  assign set_f[3] = wrap & (mode_q == M_PER);
  assign clr_f    = (wr_en && wr_addr == 3'd4) ? wr_data[3:0] : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; ctl_a_q <= '0; ctl_b_q <= '0;
      cnt_q <= '0; buf_a_q <= '0; buf_b_q <= '0;
      act_a_q <= '0; act_b_q <= '0; per_q <= '0;
      flg_q <= '0; lvl_a_q <= 1'b0; lvl_b_q <= 1'b0;
    end else begin
      if (adv) begin
        cnt_q   <= nxt_cnt;
        act_a_q <= nxt_a;
        act_b_q <= nxt_b;
        lvl_a_q <= (nxt_cnt < nxt_a);
        lvl_b_q <= (nxt_cnt < nxt_b);
      end
      flg_q <= (flg_q & ~clr_f) | set_f;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            mode_q  <= wr_data[3:0];
            ctl_a_q <= wr_data[5:4];
            ctl_b_q <= wr_data[7:6];
          end
          3'd1: buf_a_q <= wr_data;
          3'd2: buf_b_q <= wr_data;
          3'd3: per_q   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign count = cnt_q;
  assign flags = flg_q;
  assign out_a = ctl_a_q[1] & (lvl_a_q ^ ctl_a_q[0]);
  assign out_b = ctl_b_q[1] & (lvl_b_q ^ ctl_b_q[0]);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !at_top) |=> cnt_q == $past(cnt_q) + W'(1));
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  assert_period_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flg_q[0]);
  assert_limit_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode_q == M_PER) |=> flg_q[3]);
  assert_match_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q == act_b_q) |=> flg_q[2]);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[0] && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> flg_q[0]);
  assert_hold_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_a_q) && $stable(act_b_q)));
  assert_load_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> act_a_q == $past(buf_a_q));
  assert_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_a_q == (cnt_q < act_a_q)) && (lvl_b_q == (cnt_q < act_b_q)));
  assert_no_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
endmodule

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0, count;
  logic [3:0] flags;
  logic out_a, out_b;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [3:0]  m_mode, m_flags;
  logic [1:0]  m_ctla, m_ctlb;
  logic [15:0] m_cnt, m_bufa, m_bufb, m_acta, m_actb, m_per;

  pwm_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .count(count), .flags(flags), .out_a(out_a), .out_b(out_b));

  always #5 clk = ~clk;

  function automatic logic [16:0] top_of(logic [3:0] md, logic [15:0] per, logic [15:0] acta);
    case (md)
      4'd5:  return {1'b1, 16'h00FF};
      4'd6:  return {1'b1, 16'h01FF};
      4'd7:  return {1'b1, 16'h03FF};
      4'd14: return {1'b1, (per < 16'd3) ? 16'd3 : per};
      4'd15: return {1'b1, (acta < 16'd3) ? 16'd3 : acta};
      default: return 17'd0;
    endcase
  endfunction

  function automatic logic level(logic [1:0] ctl, logic [15:0] c, logic [15:0] act);
    return ctl[1] & ((c < act) ^ ctl[0]);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(bit t, bit we, logic [2:0] a, logic [15:0] d);
    logic [16:0] rt;
    logic [3:0] set, clr;
    logic wrap;
    rt = top_of(m_mode, m_per, m_acta);
    set = 0;
    if (t && rt[16]) begin
      wrap = (m_cnt == rt[15:0]);
      if (m_cnt == m_acta) set[1] = 1;
      if (m_cnt == m_actb) set[2] = 1;
      if (wrap) begin
        set[0] = 1;
        if (m_mode == 4'd14) set[3] = 1;
        if (m_mode == 4'd15) set[1] = 1;
        m_acta = m_bufa; m_actb = m_bufb;
      end
      m_cnt = wrap ? 16'd0 : m_cnt + 16'd1;
    end
    clr = (we && a == 3'd4) ? d[3:0] : 4'd0;
    m_flags = (m_flags & ~clr) | set;
    if (we) case (a)
      3'd0: begin m_mode = d[3:0]; m_ctla = d[5:4]; m_ctlb = d[7:6]; end
      3'd1: m_bufa = d;
      3'd2: m_bufb = d;
      3'd3: m_per = d;
      default: ;
    endcase
  endtask

  task automatic check_all();
    check("R2", "count", count, m_cnt);
    check("R5", "flags", flags, m_flags);
    check(m_ctla[1] ? (m_ctla[0] ? "R10" : "R9") : "R11", "out_a", out_a, level(m_ctla, m_cnt, m_acta));
    check(m_ctlb[1] ? (m_ctlb[0] ? "R10" : "R9") : "R11", "out_b", out_b, level(m_ctlb, m_cnt, m_actb));
  endtask

  task automatic step(bit t, bit we = 0, logic [2:0] a = 0, logic [15:0] d = 0);
    tick = t; wr_en = we; wr_addr = a; wr_data = d;
    model(t, we, a, d);
    @(negedge clk);
    tick = 0; wr_en = 0;
    check_all();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1d5);
    m_mode = 0; m_flags = 0; m_ctla = 0; m_ctlb = 0;
    m_cnt = 0; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0; m_per = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "count", count, 0);
    check("R1", "flags", flags, 0);
    check("R1", "outs", {out_a, out_b}, 0);
    // R3: mode 0 keeps the counter still
    step(0, 1, 3'd0, 16'h0020);
    repeat (5) step(1);
    check("R3", "count in mode 0", count, 0);
    // R4: period register 1 is raised to 3
    step(0, 1, 3'd3, 16'd1);
    step(0, 1, 3'd1, 16'd2);
    step(0, 1, 3'd2, 16'd9);
    step(0, 1, 3'd0, 16'h00EE);
    repeat (4) step(1);
    check("R4", "count after clamped period", count, 0);
    check("R5", "period and limit flags", flags & 4'h9, 4'h9);
    step(0, 1, 3'd4, 16'h000F);
    check("R7", "flags after clear", flags, 0);
    step(1); step(1);
    check("R9", "out_a at count 2 with compare 2", out_a, 0);
    check("R10", "out_b with compare above top", out_b, 0);
    step(1);
    check("R6", "compare A flag", flags[1], 1);
    // R8: a buffer write does not reach the waveform before the period ends
    step(1);
    step(1, 1, 3'd1, 16'd1);
    check("R8", "out_a at count 1 keeps old compare", out_a, 1);
    step(1); step(1);
    step(1, 1, 3'd4, 16'h0001);
    check("R7", "period flag set while cleared", flags[0], 1);
    step(1);
    check("R8", "out_a at count 1 uses new compare", out_a, 0);
    // R3: fixed 8-bit period
    step(0, 1, 3'd0, 16'h0025);
    while (m_cnt != 16'h00FF) step(1);
    check("R3", "count at 0xFF", count, 16'h00FF);
    step(1);
    check("R3", "count after 0xFF", count, 0);
    // R12: period lowered below the count
    step(0, 1, 3'd3, 16'd40);
    step(0, 1, 3'd0, 16'h002E);
    while (m_cnt != 16'd30) step(1);
    step(0, 1, 3'd3, 16'd10);
    step(0, 1, 3'd4, 16'h000F);
    while (m_cnt != 16'hFFFF) step(1);
    check("R12", "no period flag at 0xFFFF", flags[0], 0);
    step(1);
    check("R12", "wrap to zero", count, 0);
    check("R12", "no period flag after wrap", flags[0], 0);
    repeat (11) step(1);
    check("R12", "period flag at new top", flags[0], 1);
    // random configurations
    for (int k = 0; k < 10; k++) begin
      logic [3:0] md;
      logic [15:0] lim;
      case ($urandom % 7)
        0: md = 4'd5; 1: md = 4'd6; 2: md = 4'd7;
        3, 4: md = 4'd14; 5: md = 4'd15; default: md = 4'd3;
      endcase
      lim = (md == 4'd14 || md == 4'd15) ? 16'd60 : 16'd1100;
      step(0, 1, 3'd3, 16'($urandom % 50));
      step(0, 1, 3'd1, 16'($urandom % lim));
      step(0, 1, 3'd2, 16'($urandom % lim));
      step(0, 1, 3'd0, {8'd0, 8'($urandom % 4), 2'd0, md} );
      step(0, 1, 3'd0, {8'd0, 8'($urandom) & 8'hF0 | 8'(md)});
      for (int n = 0; n < 1500; n++) begin
        case ($urandom % 64)
          0: step(($urandom % 4) != 0, 1, 3'd1, 16'($urandom % lim));
          1: step(($urandom % 4) != 0, 1, 3'd2, 16'($urandom % lim));
          2: step(($urandom % 4) != 0, 1, 3'd4, 16'($urandom % 16));
          default: step(($urandom % 4) != 0);
        endcase
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule